// File: doc/BRIEF.md
# Low-Side Fault Guard

This block combines three low-side fault conditions into one shared active-low fault indication and one gate block for the three low-side switches. The three conditions are low supply, overcurrent and overtemperature. It receives comparator flags from analog sensing outside the block. For the supply these are a "supply above the on level" flag and a "supply below the off level" flag. For temperature they are an "above the trip point" flag and a "cooled below the trip point minus hysteresis" flag. There is also a raw overcurrent flag. Every flag passes through a two-flop synchronizer before the fault logic uses it.

A single alarm timer sets the minimum width of the fault indication. Each source has its own release rule:

- **Undervoltage** releases only after the timer has run out and the supply reports above its on level.
- **Overcurrent** must hold for a programmable qualification delay before it trips. It then releases on the timer alone.
- **Overtemperature** releases only when the cooled flag is seen. Its trip flag must be clear and the timer must have run out.

After any release, a gate command that is still high stays blocked until that command has been low once. This gives re-arming on the next rising edge.

Top module: `lsfault_guard`

## Requirements
- R1: Whenever the fault output is active (fault_n_o = 0), all gate_o bits are 0 regardless of gate_cmd_i.
- R2: A gate_o bit is never 1 unless its gate_cmd_i bit is 1. With no fault and an armed phase, gate_o follows gate_cmd_i in the same cycle.
- R3: Reset leaves the fault output active (0) and the gates blocked. This holds while the supply is not above its on level. The fault releases three clock edges after sup_on_i goes to 1 with sup_off_i at 0.
- R4: When sup_off_i rises, fault_n_o goes to 0 on the third clock edge after the change (two synchronizer flops plus the fault latch). It stays at 0 for PULSE_CYC+1 cycles even if the dip lasts only one cycle.
- R5: During a supply dip longer than the pulse width, the fault stays active while sup_on_i is 0. This includes the band between thresholds where both supply flags are 0. It releases three edges after sup_on_i returns to 1.
- R6: An overcurrent trips only after the synchronized oc_i has been 1 for OC_DLY_CYC consecutive cycles. The fault output goes to 0 on edge OC_DLY_CYC+2 after the input rises. A shorter pulse has no effect on fault_n_o or gate_o.
- R7: After an overcurrent trip, the fault releases PULSE_CYC+1 cycles after the trip, with oc_i already low.
- R8: Overtemperature holds the fault while ot_i is 1. After ot_i falls, the fault still holds until ot_rel_i is 1, and only then releases (three edges later).
- R9: A gate command that is high when a fault releases is held off. It passes again only after it has been low for at least one clock edge with no fault.
- R10: A new fault source that latches while the timer runs restarts the timer. Two faults that meet or overlap keep fault_n_o at 0 with no high cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_on_i | input | 1 | Low-side supply is above its on level |
| sup_off_i | input | 1 | Low-side supply is below its off level |
| oc_i | input | 1 | Overcurrent comparator flag |
| ot_i | input | 1 | Temperature is above the trip point |
| ot_rel_i | input | 1 | Temperature is below the trip point minus hysteresis |
| gate_cmd_i | input | N_PH | Low-side gate commands, active high |
| fault_n_o | output | 1 | Fault indication, 0 = fault (pull-down), 1 = released |
| gate_o | output | N_PH | Gated low-side drive signals |

## Verification
The sharpest collision happens on one edge. A one-cycle supply dip is followed by an overcurrent, timed so that the overcurrent qualification completes on exactly the edge where the undervoltage timer expires. On that edge the undervoltage latch clears and the overcurrent latch sets. The fault output must not show a single high cycle, and the release must move out by a full reloaded pulse. The scoreboard checks the fault output on the cycle before, on and after that edge, and then at the new release point. Separately, the re-arm rule is judged against a command held high across each kind of release.

// File: rtl/lsfg_pkg.sv
package lsfg_pkg;

    // Synchronized comparator flags, MSB first as packed in the top
    typedef struct packed {
        logic sup_on;
        logic sup_off;
        logic oc;
        logic ot;
        logic ot_rel;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    // Latched fault sources
    typedef struct packed {
        logic uv;
        logic oc;
        logic ot;
    } src_t;

    function automatic logic any_src(input src_t s);
        return s.uv | s.oc | s.ot;
    endfunction

endpackage

// File: rtl/lsfg_sync.sv
module lsfg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta;
            logic stab;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta <= 1'b0;
                    stab <= 1'b0;
                end else begin
                    meta <= d[i];
                    stab <= meta;
                end
            end
            assign q[i] = stab;
        end
    endgenerate
endmodule

// File: rtl/lsfg_alarm.sv
module lsfg_alarm
    import lsfg_pkg::*;
#(
    parameter int PULSE_CYC  = 1000,
    parameter int OC_DLY_CYC = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  flags_t flg,
    output src_t   src
);
    localparam int TW = $clog2(PULSE_CYC + 1);
    localparam int QW = $clog2(OC_DLY_CYC + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(PULSE_CYC);
    localparam logic [QW-1:0] Q_LAST = QW'(OC_DLY_CYC - 1);

    logic [TW-1:0] tmr;
    logic [QW-1:0] qcnt;
    src_t          lat;
    src_t          lat_nx;
    logic          set_uv, set_oc, set_ot, any_set, expired;

    assign expired = (tmr == '0);
    assign set_uv  = flg.sup_off & ~lat.uv;
    assign set_oc  = flg.oc & ~lat.oc & (qcnt == Q_LAST);
    assign set_ot  = flg.ot & ~lat.ot;
    assign any_set = set_uv | set_oc | set_ot;

    always_comb begin
        lat_nx = lat;
        if (set_uv)
            lat_nx.uv = 1'b1;
        else if (lat.uv && expired && flg.sup_on && !flg.sup_off)
            lat_nx.uv = 1'b0;

        if (set_oc)
            lat_nx.oc = 1'b1;
        else if (lat.oc && expired)
            lat_nx.oc = 1'b0;

        if (set_ot)
            lat_nx.ot = 1'b1;
        else if (lat.ot && expired && flg.ot_rel && !flg.ot)
            lat_nx.ot = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat  <= '{uv: 1'b1, oc: 1'b0, ot: 1'b0};
            tmr  <= '0;
            qcnt <= '0;
        end else begin
            lat <= lat_nx;
            if (any_set)
                tmr <= T_LOAD;
            else if (!expired)
                tmr <= tmr - 1'b1;
            if (!flg.oc || lat.oc)
                qcnt <= '0;
            else if (qcnt != Q_LAST)
                qcnt <= qcnt + 1'b1;
        end
    end

    assign src = lat;
endmodule

// File: rtl/lsfg_gate.sv
module lsfg_gate #(
    parameter int N_PH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            block,
    input  logic [N_PH-1:0] cmd,
    output logic [N_PH-1:0] drv
);
    generate
        for (genvar p = 0; p < N_PH; p++) begin : g_ph
            logic armed;
            always_ff @(posedge clk) begin
                if (rst)
                    armed <= 1'b0;
                else if (block)
                    armed <= 1'b0;
                else if (!cmd[p])
                    armed <= 1'b1;
            end
            assign drv[p] = cmd[p] & armed & ~block;
        end
    endgenerate
endmodule

// File: rtl/lsfault_guard.sv
module lsfault_guard
    import lsfg_pkg::*;
#(
    parameter int N_PH       = 3,
    parameter int PULSE_CYC  = 1000,
    parameter int OC_DLY_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sup_on_i,
    input  logic            sup_off_i,
    input  logic            oc_i,
    input  logic            ot_i,
    input  logic            ot_rel_i,
    input  logic [N_PH-1:0] gate_cmd_i,
    output logic            fault_n_o,
    output logic [N_PH-1:0] gate_o
);
    logic [FLAG_W-1:0] flg_raw;
    logic [FLAG_W-1:0] flg_q;
    flags_t            flg_s;
    src_t              src;
    logic              fault_act;

    assign flg_raw = {sup_on_i, sup_off_i, oc_i, ot_i, ot_rel_i};

    lsfg_sync #(.W(FLAG_W)) u_sync (
        .clk(clk), .rst(rst), .d(flg_raw), .q(flg_q)
    );

    assign flg_s = flags_t'(flg_q);

    lsfg_alarm #(.PULSE_CYC(PULSE_CYC), .OC_DLY_CYC(OC_DLY_CYC)) u_alarm (
        .clk(clk), .rst(rst), .flg(flg_s), .src(src)
    );

    assign fault_act = any_src(src);
    assign fault_n_o = ~fault_act;

    lsfg_gate #(.N_PH(N_PH)) u_gate (
        .clk(clk), .rst(rst), .block(fault_act), .cmd(gate_cmd_i), .drv(gate_o)
    );
endmodule

// File: rtl/lsfg_chk.sv
module lsfg_chk #(
    parameter int N_PH      = 3,
    parameter int PULSE_CYC = 1000
) (
    input logic            clk,
    input logic            rst,
    input logic            fault_n,
    input logic [N_PH-1:0] gate,
    input logic [N_PH-1:0] cmd,
    input logic            s_off,
    input logic            s_ot
);
    int   low_run;
    logic prev_fn;
    logic from_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= 0;
            prev_fn   <= 1'b0;
            from_fall <= 1'b0;
        end else begin
            prev_fn <= fault_n;
            if (fault_n) begin
                low_run   <= 0;
                from_fall <= 1'b0;
            end else begin
                if (low_run < PULSE_CYC + 4) low_run <= low_run + 1;
                if (prev_fn) from_fall <= 1'b1;
            end
        end
    end

    // R1
    gates_off_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> (gate == '0));

    // R2
    gate_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ((gate & ~cmd) == '0));

    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> (gate == '0));

    // R4
    min_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_n && from_fall) |-> (low_run >= PULSE_CYC));

    // R4
    uv_assert_chk: assert property (@(posedge clk) disable iff (rst)
        s_off |=> !fault_n);

    // R8
    ot_assert_chk: assert property (@(posedge clk) disable iff (rst)
        s_ot |=> !fault_n);
endmodule

bind lsfault_guard lsfg_chk #(.N_PH(N_PH), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst(rst), .fault_n(fault_n_o), .gate(gate_o),
    .cmd(gate_cmd_i), .s_off(flg_s.sup_off), .s_ot(flg_s.ot)
);

// File: tb/lsfault_guard_tb.sv
module lsfault_guard_tb;
    localparam int P = 20;
    localparam int D = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       sup_on, sup_off, oc, ot, ot_rel;
    logic [2:0] cmd;
    logic       fault_n;
    logic [2:0] gate;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic       fn;
        logic [2:0] g;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    lsfault_guard #(.N_PH(3), .PULSE_CYC(P), .OC_DLY_CYC(D)) u_dut (
        .clk(clk), .rst(rst), .sup_on_i(sup_on), .sup_off_i(sup_off),
        .oc_i(oc), .ot_i(ot), .ot_rel_i(ot_rel),
        .gate_cmd_i(cmd), .fault_n_o(fault_n), .gate_o(gate)
    );

    function automatic void expect_at(int at, logic fn, logic [2:0] g, string tag);
        exp_t e;
        int idx;
        e.at = at; e.fn = fn; e.g = g; e.tag = tag;
        idx = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].at > at) begin idx = i; break; end
        end
        q.insert(idx, e);
    endfunction

    // monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.at != cyc || fault_n !== e.fn || gate !== e.g) begin
                    errors++;
                    $display("FAIL %s: at cycle %0d (due %0d) fault_n=%b gate=%b, expected fault_n=%b gate=%b",
                             e.tag, cyc, e.at, fault_n, gate, e.fn, e.g);
                end
            end
        end
    end

    task automatic wait_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c;
        int c1;
        int c2;
        rst = 1'b1; sup_on = 1'b0; sup_off = 1'b1; oc = 1'b0; ot = 1'b0; ot_rel = 1'b0;
        cmd = 3'b111;
        idle(3);
        c = cyc;
        expect_at(c + 1, 1'b0, 3'b000, "R3 reset state");
        idle(2);
        rst = 1'b0;
        idle(6);
        c = cyc;
        expect_at(c + 1, 1'b0, 3'b000, "R3 blocked below on level");
        idle(2);

        // power-up release, command held high
        c = cyc;
        sup_on = 1'b1; sup_off = 1'b0;
        expect_at(c + 2, 1'b0, 3'b000, "R3 before latency");
        expect_at(c + 3, 1'b1, 3'b000, "R3 release");
        expect_at(c + 4, 1'b1, 3'b000, "R9 held command blocked");
        wait_to(c + 6);
        cmd = 3'b000;
        idle(2);
        c = cyc;
        cmd = 3'b101;
        expect_at(c + 1, 1'b1, 3'b101, "R2 pass-through");
        idle(3);

        // short supply dip
        c = cyc;
        sup_off = 1'b1; sup_on = 1'b0;
        expect_at(c + 2, 1'b1, 3'b101, "R4 latency");
        expect_at(c + 3, 1'b0, 3'b000, "R4 assert R1");
        expect_at(c + P + 3, 1'b0, 3'b000, "R4 min width");
        expect_at(c + P + 4, 1'b1, 3'b000, "R4 release R9");
        wait_to(c + 1);
        sup_off = 1'b0; sup_on = 1'b1;
        wait_to(c + P + 6);
        cmd = 3'b000;
        idle(1);
        c = cyc;
        cmd = 3'b111;
        expect_at(c + 1, 1'b1, 3'b111, "R9 rearm on new edge");
        idle(3);

        // long dip with band between thresholds
        c = cyc;
        sup_off = 1'b1; sup_on = 1'b0;
        expect_at(c + 3, 1'b0, 3'b000, "R1 long dip");
        wait_to(c + 3 * P);
        c1 = cyc;
        sup_off = 1'b0;
        expect_at(c1 + 5, 1'b0, 3'b000, "R5 between thresholds");
        wait_to(c1 + 8);
        c2 = cyc;
        sup_on = 1'b1;
        expect_at(c2 + 2, 1'b0, 3'b000, "R5 hold");
        expect_at(c2 + 3, 1'b1, 3'b000, "R5 release");
        wait_to(c2 + 5);
        cmd = 3'b000;
        idle(2);

        // overcurrent glitch shorter than delay
        c = cyc;
        cmd = 3'b101; oc = 1'b1;
        expect_at(c + 1, 1'b1, 3'b101, "R2 armed pass");
        expect_at(c + D + 2, 1'b1, 3'b101, "R6 glitch ignored");
        expect_at(c + D + 6, 1'b1, 3'b101, "R6 glitch ignored late");
        wait_to(c + D - 1);
        oc = 1'b0;
        wait_to(c + D + 8);

        // qualified overcurrent
        c = cyc;
        oc = 1'b1;
        expect_at(c + D + 1, 1'b1, 3'b101, "R6 before delay");
        expect_at(c + D + 2, 1'b0, 3'b000, "R6 trip R1");
        expect_at(c + D + P + 2, 1'b0, 3'b000, "R7 hold");
        expect_at(c + D + P + 3, 1'b1, 3'b000, "R7 release R9");
        wait_to(c + D + 3);
        oc = 1'b0;
        wait_to(c + D + P + 5);
        cmd = 3'b000;
        idle(2);

        // overtemperature with hysteresis
        c = cyc;
        ot = 1'b1;
        expect_at(c + 3, 1'b0, 3'b000, "R8 set");
        wait_to(c + 5);
        c1 = cyc;
        ot = 1'b0;
        expect_at(c1 + 2 * P, 1'b0, 3'b000, "R8 hysteresis hold");
        wait_to(c1 + 2 * P + 1);
        c2 = cyc;
        ot_rel = 1'b1;
        expect_at(c2 + 2, 1'b0, 3'b000, "R8 before release");
        expect_at(c2 + 3, 1'b1, 3'b000, "R8 release");
        wait_to(c2 + 4);
        ot_rel = 1'b0;
        idle(3);

        // back-to-back: overcurrent trips on the edge the dip timer expires
        c = cyc;
        sup_off = 1'b1; sup_on = 1'b0;
        expect_at(c + 3, 1'b0, 3'b000, "R10 first fault");
        expect_at(c + P + 3, 1'b0, 3'b000, "R10 before handover");
        expect_at(c + P + 4, 1'b0, 3'b000, "R10 no glitch");
        expect_at(c + P + 5, 1'b0, 3'b000, "R10 after handover");
        expect_at(c + 2 * P + 4, 1'b0, 3'b000, "R10 restarted timer");
        expect_at(c + 2 * P + 5, 1'b1, 3'b000, "R10 release");
        wait_to(c + 1);
        sup_off = 1'b0; sup_on = 1'b1;
        wait_to(c + P + 2 - D);
        oc = 1'b1;
        wait_to(c + P + 6);
        oc = 1'b0;
        wait_to(c + 2 * P + 8);

        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule